// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Status

This block recovers characters from an asynchronous serial line. The line is sampled on a rate enable that pulses sixteen times per bit. A start bit is accepted only if the line is still low half a bit later. Data is taken least-significant bit first. An optional parity bit may follow the data, and then one stop bit. Each character goes into a small receive queue together with three status bits: break, framing error, and parity (or, in multidrop mode, the address/data bit). The status bits leave the queue together with their data. The host sees the oldest entry at the output. It removes that entry with a pop strobe.

When the queue is full, one more completed character can wait in a single holding stage, which stands for the shift register. If another character completes while that stage is occupied, the waiting character and its status are lost. A sticky overrun flag is then raised, and only an error-reset command clears it. After a break, the receiver writes nothing more until the line has been high for half a bit time.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_rdy`, `fifo_full` and `ovr_err` are all low.
- R2: A low level on `rxd` that is gone when it is resampled half a bit later is treated as a false start. No character is stored.
- R3: `char_len` selects 5, 6, 7 or 8 data bits (codes 0 to 3). Data bit 0 is received first and appears at `rd_data[0]`. Bits above the programmed length read as zero.
- R4: `par_mode` is coded as follows. 0 means a parity bit is present and checked: `par_odd`=0 selects even parity and 1 selects odd. 1 means the parity bit is forced: its expected value is `par_odd`. 2 means no parity bit. 3 means multidrop. In modes 0 and 1, `rd_pe` flags a wrong parity bit. In mode 3, `rd_pe` holds the received address/data bit. In mode 2, `rd_pe` is 0.
- R5: The queue holds 4 entries in arrival order. `rx_rdy` is high while the queue holds at least one entry. A pop removes the head entry. While the queue is not empty and no pop occurs, the head entry does not change.
- R6: `fifo_full` is high exactly when the queue holds 4 entries. `fifo_full` high implies `rx_rdy` high.
- R7: With the queue full, one completed character waits in the holding stage. If another character completes while the stage is occupied, `ovr_err` rises, the waiting character is discarded, and the new character takes its place. The queue contents are untouched. A rise of `ovr_err` is always preceded by a full queue. Once space appears, the waiting character enters the queue.
- R8: `ovr_err` stays high until a one-cycle `clr_err` pulse clears it.
- R9: A low sample at the middle of the stop bit sets `rd_fe` for that character. The character's data is still stored.
- R10: A character whose data bits, parity bit (if present) and stop bit are all zero is stored once, with `rd_brk`=1 and `rd_fe`=1. Nothing more is stored until `rxd` has been high for 8 oversampling ticks.
- R11: When a low level begins partway through a character, that character is stored with `rd_fe`=1 and `rd_brk`=0. The break is reported only on the following character time, which is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial receive line, idle high |
| char_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| par_mode | input | 2 | 0 parity, 1 forced parity, 2 none, 3 multidrop |
| par_odd | input | 1 | Parity sense or forced value |
| pop | input | 1 | Remove head entry |
| clr_err | input | 1 | Clear overrun flag |
| rd_data | output | 8 | Head entry data |
| rd_brk | output | 1 | Head entry break flag |
| rd_fe | output | 1 | Head entry framing error |
| rd_pe | output | 1 | Head entry parity error or address/data bit |
| rx_rdy | output | 1 | Queue not empty |
| fifo_full | output | 1 | Queue holds 4 entries |
| ovr_err | output | 1 | Sticky overrun |

## Verification
The properties rely on `pop` being raised only while the queue holds data. They also rely on `char_len`, `par_mode` and `par_odd` staying stable for the whole of a frame. The bench changes configuration only while the line is idle. It pops only after it has seen `rx_rdy` high. It drives `rxd` in whole bit periods of 16 ticks, so every sample falls well inside a bit.

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int DEPTH = 4,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic [1:0] char_len,
  input  logic [1:0] par_mode,
  input  logic       par_odd,
  input  logic       pop,
  input  logic       clr_err,
  output logic [7:0] rd_data,
  output logic       rd_brk,
  output logic       rd_fe,
  output logic       rd_pe,
  output logic       rx_rdy,
  output logic       fifo_full,
  output logic       ovr_err
);
  localparam int PW   = $clog2(DEPTH);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int EW   = 11;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;
  st_t st;

  logic [CW-1:0] tcnt;
  logic [2:0]    bidx;
  logic [7:0]    sh;
  logic          pbit;
  logic          done;
  logic [EW-1:0] newent;

  wire [2:0] last_idx = 3'(char_len) + 3'd4;
  wire       has_par  = par_mode != 2'd2;
  wire       mid      = tcnt == CW'(OSR - 1);

  logic stop_lo, brk_c, pe_c;
  always_comb begin
    stop_lo = !rxd;
    brk_c   = stop_lo && sh == 8'd0 && !(has_par && pbit);
    case (par_mode)
      2'd0:    pe_c = ^sh ^ pbit ^ par_odd;
      2'd1:    pe_c = pbit != par_odd;
      2'd3:    pe_c = pbit;
      default: pe_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (!rst_n) begin
      st   <= S_IDLE;
      tcnt <= '0;
      bidx <= '0;
      sh   <= '0;
      pbit <= 1'b0;
      newent <= '0;
    end else if (os_tick) begin
      case (st)
        S_IDLE: if (!rxd) begin st <= S_START; tcnt <= '0; end
        S_START:
          if (tcnt == CW'(HALF - 1)) begin
            tcnt <= '0;
            bidx <= '0;
            sh   <= '0;
            pbit <= 1'b0;
            st   <= rxd ? S_IDLE : S_DATA;
          end else tcnt <= tcnt + 1'b1;
        S_DATA: begin
          tcnt <= tcnt + 1'b1;
          if (mid) begin
            sh[bidx] <= rxd;
            bidx     <= bidx + 1'b1;
            if (bidx == last_idx) st <= has_par ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          tcnt <= tcnt + 1'b1;
          if (mid) begin pbit <= rxd; st <= S_STOP; end
        end
        S_STOP: begin
          tcnt <= tcnt + 1'b1;
          if (mid) begin
            done   <= 1'b1;
            newent <= {brk_c, stop_lo, pe_c, sh};
            tcnt   <= '0;
            st     <= brk_c ? S_BRK : S_IDLE;
          end
        end
        S_BRK:
          if (!rxd) tcnt <= '0;
          else if (tcnt == CW'(HALF - 1)) st <= S_IDLE;
          else tcnt <= tcnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic          hold_v;
  logic [EW-1:0] hold;

  wire           full   = cnt == (PW+1)'(DEPTH);
  wire           do_pop = pop && cnt != '0;
  wire           push   = !full && (hold_v || done);
  wire [EW-1:0]  pdata  = hold_v ? hold : newent;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= pdata;
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      hold_v <= 1'b0; hold <= '0; ovr_err <= 1'b0;
    end else begin
      if (push)   wp <= wp + 1'b1;
      if (do_pop) rp <= rp + 1'b1;
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(do_pop);
      if (done && (hold_v || full)) begin
        hold   <= newent;
        hold_v <= 1'b1;
      end else if (hold_v && !full) hold_v <= 1'b0;
      if (done && hold_v && full) ovr_err <= 1'b1;
      else if (clr_err)           ovr_err <= 1'b0;
    end
  end

  assign {rd_brk, rd_fe, rd_pe, rd_data} = mem[rp];
  assign rx_rdy    = cnt != '0;
  assign fifo_full = full;
endmodule

module serial_rx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pop,
  input logic       clr_err,
  input logic [7:0] rd_data,
  input logic       rx_rdy,
  input logic       fifo_full,
  input logic       ovr_err
);
  assert_full_means_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> rx_rdy);
  assert_head_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rdy && !pop) |=> (rx_rdy && $stable(rd_data)));
  assert_overrun_after_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(fifo_full));
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && !clr_err) |=> ovr_err);
  assert_overrun_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !fifo_full) |=> !ovr_err);
endmodule

bind serial_rx_core serial_rx_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pop(pop), .clr_err(clr_err), .rd_data(rd_data),
  .rx_rdy(rx_rdy), .fifo_full(fifo_full), .ovr_err(ovr_err)
);

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OSR = 16;
  localparam int NV  = 11;

  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1;
  logic [1:0] char_len = 2'd3, par_mode = 2'd2;
  logic par_odd = 1'b0, pop = 1'b0, clr_err = 1'b0;
  logic [7:0] rd_data;
  logic rd_brk, rd_fe, rd_pe, rx_rdy, fifo_full, ovr_err;
  int checks = 0, errors = 0, cycles = 0;

  serial_rx_core dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) os_tick <= rst_n ? ~os_tick : 1'b0;

  // {len, mode, odd, data, pbit, stop, exp_data, exp_brk, exp_fe, exp_pe}
  localparam logic [25:0] VEC [NV] = '{
    {2'd3, 2'd2, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 3'b000},
    {2'd0, 2'd2, 1'b0, 8'hF3, 1'b0, 1'b1, 8'h13, 3'b000},
    {2'd3, 2'd0, 1'b0, 8'h07, 1'b1, 1'b1, 8'h07, 3'b000},
    {2'd3, 2'd0, 1'b0, 8'h07, 1'b0, 1'b1, 8'h07, 3'b001},
    {2'd3, 2'd0, 1'b1, 8'h07, 1'b0, 1'b1, 8'h07, 3'b000},
    {2'd3, 2'd1, 1'b1, 8'h3C, 1'b1, 1'b1, 8'h3C, 3'b000},
    {2'd3, 2'd1, 1'b1, 8'h3C, 1'b0, 1'b1, 8'h3C, 3'b001},
    {2'd3, 2'd3, 1'b0, 8'h42, 1'b1, 1'b1, 8'h42, 3'b001},
    {2'd3, 2'd3, 1'b0, 8'h42, 1'b0, 1'b1, 8'h42, 3'b000},
    {2'd2, 2'd2, 1'b0, 8'h55, 1'b0, 1'b0, 8'h55, 3'b010},
    {2'd1, 2'd2, 1'b0, 8'h2A, 1'b0, 1'b1, 8'h2A, 3'b000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_time(input logic v);
    rxd = v;
    repeat (2*OSR) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic par, input logic pb, input logic stop);
    bit_time(1'b0);
    for (int i = 0; i < int'(char_len) + 5; i++) bit_time(d[i]);
    if (par) bit_time(pb);
    bit_time(stop);
    bit_time(1'b1);
  endtask

  task automatic do_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog R5 actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 rx_rdy", rx_rdy, 0);
    chk("R1 fifo_full", fifo_full, 0);
    chk("R1 ovr_err", ovr_err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [25:0] v;
      string tag;
      v = VEC[k];
      char_len = v[25:24]; par_mode = v[23:22]; par_odd = v[21];
      tag = v[11] == 1'b0 ? "R9" : (v[23:22] == 2'd2 ? "R3" : "R4");
      send(v[20:13], v[23:22] != 2'd2, v[12], v[11]);
      chk({tag, " rdy"}, rx_rdy, 1);
      chk({tag, " data"}, rd_data, v[10:3]);
      chk({tag, " brk"}, rd_brk, v[2]);
      chk({tag, " fe"}, rd_fe, v[1]);
      chk({tag, " pe"}, rd_pe, v[0]);
      do_pop();
      chk("R5 empty after pop", rx_rdy, 0);
    end

    char_len = 2'd3; par_mode = 2'd2;
    rxd = 1'b0; repeat (8) @(negedge clk);
    rxd = 1'b1; repeat (12*2*OSR) @(negedge clk);
    chk("R2 false start", rx_rdy, 0);

    bit_time(1'b0);
    for (int i = 0; i < 8; i++) bit_time(i >= 4);
    repeat (22) bit_time(1'b0);
    repeat (2) bit_time(1'b1);
    chk("R11 rdy", rx_rdy, 1);
    chk("R11 data", rd_data, 8'hF0);
    chk("R11 brk", rd_brk, 0);
    chk("R11 fe", rd_fe, 1);
    do_pop();
    chk("R10 rdy", rx_rdy, 1);
    chk("R10 data", rd_data, 8'h00);
    chk("R10 brk", rd_brk, 1);
    chk("R10 fe", rd_fe, 1);
    do_pop();
    chk("R10 single slot", rx_rdy, 0);
    send(8'h3B, 1'b0, 1'b0, 1'b1);
    chk("R10 released", rd_data, 8'h3B);
    do_pop();

    for (int i = 1; i <= 4; i++) send(8'(8'h10 + i), 1'b0, 1'b0, 1'b1);
    chk("R6 full", fifo_full, 1);
    chk("R7 no ovr yet", ovr_err, 0);
    send(8'h15, 1'b0, 1'b0, 1'b1);
    chk("R7 held no ovr", ovr_err, 0);
    send(8'h16, 1'b0, 1'b0, 1'b1);
    chk("R7 ovr set", ovr_err, 1);
    chk("R7 head kept", rd_data, 8'h11);
    do_pop();
    chk("R6 refilled from hold", fifo_full, 1);
    chk("R5 order 2", rd_data, 8'h12);
    do_pop();
    chk("R6 not full", fifo_full, 0);
    chk("R5 order 3", rd_data, 8'h13);
    do_pop();
    chk("R5 order 4", rd_data, 8'h14);
    do_pop();
    chk("R7 waiting char replaced", rd_data, 8'h16);
    do_pop();
    chk("R5 drained", rx_rdy, 0);
    chk("R8 sticky", ovr_err, 1);
    clr_err = 1'b1; @(negedge clk); clr_err = 1'b0; @(negedge clk);
    chk("R8 cleared", ovr_err, 0);

    finish_run();
  end
endmodule